// File: doc/BRIEF.md
# Root Port Power Management Register

This block holds the power-management control and status word of a PCI Express-style root port. Configuration software reaches it through a simple read/write strobe interface that carries a byte address, byte enables and 32-bit data. The word has three live fields. The first is a two-bit device power state. The second is a wake-event enable bit. The third is a read-only wake-event status bit, which is set when a downstream event is reported. Every other bit reads as zero.

Two registered outputs follow the power state. While the port sits in D3hot, they tell the surrounding decode logic to refuse I/O space, memory space and Type 1 configuration transactions. The port's own configuration space stays reachable, so software can always bring it back to D0.

The block runs on two synchronous active-low resets. The warm reset clears the power state, the status bit, the gating outputs and the read path. The resume-well reset clears only the enable bit, which therefore survives a warm reset.

Top module: `rpm_top`

## Requirements
- R1: After both resets, a read of the register returns 0x00000000, and io_mem_blocked and type1_cfg_blocked are both 0.
- R2: Bits 1:0 hold the power state, where 00 means D0 and 11 means D3hot. A write to the register with cfg_be[0] set loads wdata[1:0] when the code is 00 or 11. With cfg_be[0] clear, the field keeps its value.
- R3: A write of 01 or 10 to bits 1:0 is dropped, and the power state keeps its previous value.
- R4: Bit 8 is the wake enable. A write with cfg_be[1] set loads wdata[8]. With cfg_be[1] clear, the bit keeps its value.
- R5: The wake enable is cleared only by resume_rst_n. Asserting warm_rst_n leaves it unchanged, and writes are not accepted while warm_rst_n is low.
- R6: Bit 15 is the wake status. It becomes 1 in the cycle after a pme_received pulse and stays 1 until warm reset. Configuration writes never change it.
- R7: Bits 31:16, 14:9 and 7:2 always read as zero, and writes to them have no effect.
- R8: io_mem_blocked and type1_cfg_blocked rise on the clock edge after the power state becomes 11 and fall on the edge after it leaves 11. In D3hot, the register stays readable and writable.
- R9: The register lives at byte offset REG_OFFSET (default 0xA4), compared on address bits above bit 1. cfg_rvalid and cfg_rdata appear one cycle after cfg_rd. A read of any other address returns zero, and a write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| warm_rst_n | input | 1 | Synchronous active-low warm reset |
| resume_rst_n | input | 1 | Synchronous active-low resume-well reset (wake enable only) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after cfg_rd |
| cfg_rvalid | output | 1 | Read data valid |
| pme_received | input | 1 | One-cycle pulse: downstream wake event seen |
| io_mem_blocked | output | 1 | I/O and memory decode refused (D3hot) |
| type1_cfg_blocked | output | 1 | Type 1 configuration decode refused (D3hot) |

## Verification
The bench builds the block with its defaults: a 12-bit address and the register at offset 0xA4. At that width the word sits well inside the decoded range, so the neighbouring offset 0xA8 can serve as a miss address for both reads and writes. The byte-enable combinations, the dropped power-state codes, the two reset domains and the one-cycle lag of the gating outputs can all be reached through the ports.

// File: rtl/rpm_pkg.sv
// Package rpm_pkg
// Shared constants and the field bundle for the root port power
// management register. Bit positions are fixed by software's view of
// the word; nothing here depends on a parameter.
package rpm_pkg;
    localparam int          WORD_W     = 32;
    localparam int          BE_W       = WORD_W / 8;
    localparam int          PS_LSB     = 0;
    localparam int          PME_EN_BIT = 8;
    localparam int          PME_ST_BIT = 15;
    localparam logic [1:0]  PS_D0      = 2'b00;
    localparam logic [1:0]  PS_D3HOT   = 2'b11;

    // Live register fields, gathered for the read path.
    typedef struct packed {
        logic       pme_st;
        logic       pme_en;
        logic [1:0] ps;
    } pm_fields_t;
endpackage

// File: rtl/rpm_power_state.sv
// Module rpm_power_state
// Holds the two-bit power state and drives the registered decode-gating
// outputs. Assumes wr_hit is already qualified by the address match and by
// warm reset. Only the codes D0 and D3hot are ever stored.
module rpm_power_state
    import rpm_pkg::*;
(
    input  logic       clk,
    input  logic       warm_rst_n,
    input  logic       wr_hit,
    input  logic       be0,
    input  logic [1:0] wdata_ps,
    output logic [1:0] ps,
    output logic       io_mem_blocked,
    output logic       type1_cfg_blocked
);
    logic code_legal;
    logic [1:0] ps_q;

    // Accept only the two defined power state codes.
    always_comb begin
        code_legal = (wdata_ps == PS_D0) || (wdata_ps == PS_D3HOT);
    end

    // Power state storage, loaded on an enabled legal write.
    always_ff @(posedge clk) begin
        if (!warm_rst_n) begin
            ps_q <= PS_D0;
        end else if (wr_hit && be0 && code_legal) begin
            ps_q <= wdata_ps;
        end
    end

    // Gating outputs follow the stored state one edge later.
    always_ff @(posedge clk) begin
        if (!warm_rst_n) begin
            io_mem_blocked    <= 1'b0;
            type1_cfg_blocked <= 1'b0;
        end else begin
            io_mem_blocked    <= (ps_q == PS_D3HOT);
            type1_cfg_blocked <= (ps_q == PS_D3HOT);
        end
    end

    assign ps = ps_q;
endmodule

// File: rtl/rpm_pme_bits.sv
// Module rpm_pme_bits
// Holds the wake enable bit (resume-well domain) and the wake status bit
// (warm domain). Assumes wr_hit is already gated by warm reset, so the
// enable bit cannot be written while the warm reset is held.
module rpm_pme_bits (
    input  logic clk,
    input  logic warm_rst_n,
    input  logic resume_rst_n,
    input  logic wr_hit,
    input  logic be1,
    input  logic wdata_en,
    input  logic pme_received,
    output logic pme_en,
    output logic pme_st
);
    // Sticky enable, cleared only by the resume-well reset.
    always_ff @(posedge clk) begin
        if (!resume_rst_n) begin
            pme_en <= 1'b0;
        end else if (wr_hit && be1) begin
            pme_en <= wdata_en;
        end
    end

    // Status set by a downstream event, held until warm reset.
    always_ff @(posedge clk) begin
        if (!warm_rst_n) begin
            pme_st <= 1'b0;
        end else if (pme_received) begin
            pme_st <= 1'b1;
        end
    end
endmodule

// File: rtl/rpm_readback.sv
// Module rpm_readback
// Assembles the 32-bit word from the live fields and registers it on a
// read strobe. Reserved bits are tied to zero. A read that misses the
// register returns zero.
module rpm_readback
    import rpm_pkg::*;
(
    input  logic              clk,
    input  logic              warm_rst_n,
    input  logic              rd,
    input  logic              hit,
    input  pm_fields_t        fields,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    logic [WORD_W-1:0] word;

    // Place each field at its bit position; all else is zero.
    always_comb begin
        word                  = '0;
        word[PS_LSB +: 2]     = fields.ps;
        word[PME_EN_BIT]      = fields.pme_en;
        word[PME_ST_BIT]      = fields.pme_st;
    end

    // Register the read response one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!warm_rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) begin
                rdata <= hit ? word : '0;
            end
        end
    end
endmodule

// File: rtl/rpm_top.sv
// Module rpm_top
// Root port power management register: address decode, write
// qualification and wiring of the state, wake and read-back units.
// Assumes cfg_addr is a byte address and that the register is
// dword-aligned at REG_OFFSET.
module rpm_top
    import rpm_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int REG_OFFSET = 'hA4
) (
    input  logic              clk,
    input  logic              warm_rst_n,
    input  logic              resume_rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              cfg_rvalid,
    input  logic              pme_received,
    output logic              io_mem_blocked,
    output logic              type1_cfg_blocked
);
    localparam logic [ADDR_W-1:0] OFS_FULL = ADDR_W'(REG_OFFSET);
    localparam logic [ADDR_W-3:0] DW_IDX   = OFS_FULL[ADDR_W-1:2];

    logic       hit;
    logic       wr_hit;
    logic [1:0] ps_q;
    logic       pme_en_q;
    logic       pme_st_q;
    pm_fields_t fields;

    // Address match on dword index; writes blocked during warm reset.
    always_comb begin
        hit    = (cfg_addr[ADDR_W-1:2] == DW_IDX);
        wr_hit = cfg_wr && hit && warm_rst_n;
    end

    // Bundle live fields for the read path.
    always_comb begin
        fields.ps     = ps_q;
        fields.pme_en = pme_en_q;
        fields.pme_st = pme_st_q;
    end

    rpm_power_state u_state (
        .clk               (clk),
        .warm_rst_n        (warm_rst_n),
        .wr_hit            (wr_hit),
        .be0               (cfg_be[0]),
        .wdata_ps          (cfg_wdata[PS_LSB +: 2]),
        .ps                (ps_q),
        .io_mem_blocked    (io_mem_blocked),
        .type1_cfg_blocked (type1_cfg_blocked)
    );

    rpm_pme_bits u_pme (
        .clk          (clk),
        .warm_rst_n   (warm_rst_n),
        .resume_rst_n (resume_rst_n),
        .wr_hit       (wr_hit),
        .be1          (cfg_be[1]),
        .wdata_en     (cfg_wdata[PME_EN_BIT]),
        .pme_received (pme_received),
        .pme_en       (pme_en_q),
        .pme_st       (pme_st_q)
    );

    rpm_readback u_rb (
        .clk        (clk),
        .warm_rst_n (warm_rst_n),
        .rd         (cfg_rd),
        .hit        (hit),
        .fields     (fields),
        .rdata      (cfg_rdata),
        .rvalid     (cfg_rvalid)
    );
endmodule

// File: rtl/rpm_checker.sv
// Module rpm_checker
// Temporal properties of rpm_top, attached by bind. Observes the top
// ports and the stored fields. It drives nothing.
module rpm_checker
    import rpm_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int REG_OFFSET = 'hA4
) (
    input logic              clk,
    input logic              warm_rst_n,
    input logic              resume_rst_n,
    input logic              cfg_wr,
    input logic              cfg_rd,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [BE_W-1:0]   cfg_be,
    input logic [WORD_W-1:0] cfg_wdata,
    input logic [WORD_W-1:0] cfg_rdata,
    input logic              cfg_rvalid,
    input logic              pme_received,
    input logic              io_mem_blocked,
    input logic              type1_cfg_blocked,
    input logic [1:0]        ps,
    input logic              pme_en,
    input logic              pme_st
);
    localparam logic [ADDR_W-1:0] OFS_FULL = ADDR_W'(REG_OFFSET);
    localparam logic [ADDR_W-3:0] DW_IDX   = OFS_FULL[ADDR_W-1:2];

    logic bad_ps_wr;
    // Enabled write to this register carrying an undefined state code.
    always_comb begin
        bad_ps_wr = cfg_wr && cfg_be[0] && (cfg_addr[ADDR_W-1:2] == DW_IDX)
                    && (cfg_wdata[1:0] == 2'b01 || cfg_wdata[1:0] == 2'b10);
    end

    AST_PS_LEGAL: assert property (@(posedge clk) disable iff (!warm_rst_n)
        (ps == PS_D0) || (ps == PS_D3HOT)); // R2
    AST_BAD_CODE_DROPPED: assert property (@(posedge clk) disable iff (!warm_rst_n)
        bad_ps_wr |=> $stable(ps)); // R3
    AST_EN_SURVIVES_WARM: assert property (@(posedge clk) disable iff (!resume_rst_n)
        !warm_rst_n |=> $stable(pme_en)); // R5
    AST_STATUS_SETS: assert property (@(posedge clk) disable iff (!warm_rst_n)
        pme_received |=> pme_st); // R6
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!warm_rst_n)
        pme_st |=> pme_st); // R6
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!warm_rst_n)
        (cfg_rdata[31:16] == '0) && (cfg_rdata[14:9] == '0) && (cfg_rdata[7:2] == '0)); // R7
    AST_GATE_RISES: assert property (@(posedge clk) disable iff (!warm_rst_n)
        (ps == PS_D3HOT) |=> (io_mem_blocked && type1_cfg_blocked)); // R8
    AST_GATE_FALLS: assert property (@(posedge clk) disable iff (!warm_rst_n)
        (ps == PS_D0) |=> (!io_mem_blocked && !type1_cfg_blocked)); // R8
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!warm_rst_n)
        cfg_rd |=> cfg_rvalid); // R9
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!warm_rst_n)
        !cfg_rd |=> !cfg_rvalid); // R9
endmodule

bind rpm_top rpm_checker #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) u_rpm_checker (
    .clk               (clk),
    .warm_rst_n        (warm_rst_n),
    .resume_rst_n      (resume_rst_n),
    .cfg_wr            (cfg_wr),
    .cfg_rd            (cfg_rd),
    .cfg_addr          (cfg_addr),
    .cfg_be            (cfg_be),
    .cfg_wdata         (cfg_wdata),
    .cfg_rdata         (cfg_rdata),
    .cfg_rvalid        (cfg_rvalid),
    .pme_received      (pme_received),
    .io_mem_blocked    (io_mem_blocked),
    .type1_cfg_blocked (type1_cfg_blocked),
    .ps                (ps_q),
    .pme_en            (pme_en_q),
    .pme_st            (pme_st_q)
);

// File: tb/test_rpm_top.sv
// Bench for rpm_top: a vector table walked by one loop, then directed
// tests for the resets, the wake status, address misses and the gating lag.
module test_rpm_top;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] REG_A  = 12'hA4;
    localparam logic [ADDR_W-1:0] MISS_A = 12'hA8;
    localparam int NVEC = 8;
    // Each entry: {byte enables, write data, expected read-back}.
    localparam logic [67:0] VEC [NVEC] = '{
        {4'hF, 32'hFFFF_FFFF, 32'h0000_0103},   // R2 R4 R7 all ones
        {4'hF, 32'h0000_0001, 32'h0000_0003},   // R3 code 01 dropped, enable cleared
        {4'hF, 32'h0000_0002, 32'h0000_0003},   // R3 code 10 dropped
        {4'h2, 32'h0000_0100, 32'h0000_0103},   // R4 byte 1 only
        {4'h1, 32'h0000_0000, 32'h0000_0100},   // R2 byte 0 only, to D0
        {4'hC, 32'hFFFF_FFFF, 32'h0000_0100},   // R7 upper bytes no effect
        {4'hF, 32'h0000_0000, 32'h0000_0000},   // R4 clear
        {4'h1, 32'hFFFF_FC03, 32'h0000_0003}    // R2 to D3hot
    };

    logic              clk = 1'b0;
    logic              warm_rst_n = 1'b0;
    logic              resume_rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic              cfg_rd = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [3:0]        cfg_be = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              cfg_rvalid;
    logic              pme_received = 1'b0;
    logic              io_mem_blocked;
    logic              type1_cfg_blocked;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] rd_val;

    always #5 clk = ~clk;

    rpm_top #(.ADDR_W(ADDR_W), .REG_OFFSET('hA4)) i_rpm_top (
        .clk (clk), .warm_rst_n (warm_rst_n), .resume_rst_n (resume_rst_n),
        .cfg_wr (cfg_wr), .cfg_rd (cfg_rd), .cfg_addr (cfg_addr),
        .cfg_be (cfg_be), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .cfg_rvalid (cfg_rvalid), .pme_received (pme_received),
        .io_mem_blocked (io_mem_blocked), .type1_cfg_blocked (type1_cfg_blocked)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One write, driven between edges and taken at one rising edge.
    task automatic cfg_write(input logic [ADDR_W-1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
    endtask

    // One read; data is sampled at the falling edge after the response edge.
    task automatic cfg_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        @(negedge clk);
        cfg_rd = 1'b0;
        check("R9 rvalid", {31'd0, cfg_rvalid}, 32'd1);
        d = cfg_rdata;
    endtask

    initial begin
        #200_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        warm_rst_n = 1'b1; resume_rst_n = 1'b1;

        // R1 reset state
        check("R1 io_mem_blocked", {31'd0, io_mem_blocked}, 32'd0);
        check("R1 type1_cfg_blocked", {31'd0, type1_cfg_blocked}, 32'd0);
        check("R9 rvalid idle", {31'd0, cfg_rvalid}, 32'd0);
        cfg_read(REG_A, rd_val);
        check("R1 reset word", rd_val, 32'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            cfg_write(REG_A, VEC[i][67:64], VEC[i][63:32]);
            cfg_read(REG_A, rd_val);
            check("R2/R3/R4/R7 vector word", rd_val, VEC[i][31:0]);
            check("R8 vector gate", {30'd0, io_mem_blocked, type1_cfg_blocked},
                  (VEC[i][1:0] == 2'b11) ? 32'd3 : 32'd0);
        end

        // R8 exact lag: in D3hot now; go to D0, gates still high one edge
        cfg_write(REG_A, 4'h1, 32'h0);
        check("R8 gate lag fall", {31'd0, io_mem_blocked}, 32'd1);
        @(negedge clk);
        check("R8 gate fell", {30'd0, io_mem_blocked, type1_cfg_blocked}, 32'd0);
        cfg_write(REG_A, 4'h1, 32'h3);
        check("R8 gate lag rise", {31'd0, type1_cfg_blocked}, 32'd0);
        @(negedge clk);
        check("R8 gate rose", {30'd0, io_mem_blocked, type1_cfg_blocked}, 32'd3);

        // R9 miss address: write ignored, read returns zero
        cfg_write(MISS_A, 4'hF, 32'h0000_0100);
        cfg_read(MISS_A, rd_val);
        check("R9 miss read", rd_val, 32'h0);
        cfg_read(REG_A, rd_val);
        check("R9 miss write ignored", rd_val, 32'h0000_0003);

        // R6 wake status set, held, read-only
        @(negedge clk); pme_received = 1'b1;
        @(negedge clk); pme_received = 1'b0;
        cfg_read(REG_A, rd_val);
        check("R6 status set", rd_val, 32'h0000_8003);
        cfg_write(REG_A, 4'hF, 32'h0000_0100);
        cfg_read(REG_A, rd_val);
        check("R6 status not writable", rd_val, 32'h0000_8100);

        // R5 warm reset keeps enable, clears the rest; writes blocked during it
        cfg_write(REG_A, 4'h1, 32'h3);
        @(negedge clk);
        warm_rst_n = 1'b0;
        cfg_wr = 1'b1; cfg_addr = REG_A; cfg_be = 4'h2; cfg_wdata = 32'h0;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        @(negedge clk);
        warm_rst_n = 1'b1;
        check("R5 gate cleared by warm reset", {31'd0, io_mem_blocked}, 32'd0);
        cfg_read(REG_A, rd_val);
        check("R5 enable survives warm reset", rd_val, 32'h0000_0100);

        // R5 resume reset clears enable
        @(negedge clk); resume_rst_n = 1'b0;
        @(negedge clk); resume_rst_n = 1'b1;
        cfg_read(REG_A, rd_val);
        check("R5 resume reset clears enable", rd_val, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule